// File: doc/BRIEF.md
# Serial Configuration Slave for a Clock Generator

This block is the two-wire serial slave through which a host programs the byte-wide configuration registers of a clock generator. A free-running system clock oversamples the serial clock (SCL) and serial data (SDA) lines. The block recognises start and stop conditions and answers one fixed write address and one fixed read address. It pulls SDA low through an open-drain enable output, both to acknowledge and to send data.

Every write carries two header bytes after the address. The slave acknowledges both and then discards them. All later bytes fill the register bank in order, starting at register 0.

A read first returns the number of implemented registers as a two-digit binary-coded-decimal byte. The register contents follow, starting at register 0. The register bank is always visible on a parallel output bus that feeds the clock-control logic.

Top module: `cfg_serial_slave`

## Requirements
- R1: A byte of 0xD2 sent after a start, taken MSB first with the R/W flag as bit 0, is acknowledged: the slave holds SDA low for the whole high phase of the ninth SCL pulse.
- R2: A byte of 0xD3 after a start is acknowledged. Any other address byte gets no acknowledge, and the slave then leaves SDA released for all later bytes until the next start.
- R3: In a write, the two bytes that follow the address are both acknowledged and change no register.
- R4: The third and later bytes of a write are acknowledged and stored into registers 0, 1, 2 and so on. A stop may come after any byte, including directly after the header. Registers that receive no byte keep their value.
- R5: Data bytes beyond the last register (NUM_REGS, default 12) are acknowledged but not stored.
- R6: After an acknowledged read address, the slave sends the register count in BCD first (0x12 for 12 registers), MSB first. It then sends register 0, register 1 and so on. Any index past the last register reads as 0x00.
- R7: A high (NACK) from the master on the ninth bit of a read byte ends the transfer, and the slave drives nothing until the next start.
- R8: A start that arrives in the middle of a transfer abandons the byte in progress without storing it and restarts address matching.
- R9: After reset every register holds 0xFF and SDA is released.
- R10: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 cycles per SCL phase |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| cfg_o | output | NUM_REGS*8 | Register bank, register n on bits [8n+7:8n] |

## Verification
On every cycle, the assertions check these properties:
- a rejected address leaves the slave idle and silent;
- a master NACK during a read returns the slave to idle;
- stores come only from data bytes and only into implemented registers;
- the register bank holds its value when no store is requested;
- the SDA drive matches the bit being sent and changes only while SCL is low.

Only the bench scenarios can show the rest:
- the actual byte sequences on the wire, namely acknowledge timing, the BCD count, the register order and the zero fill past the end;
- that header bytes and dropped data leave the bank untouched;
- that a start in the middle of a byte abandons that byte.

// File: rtl/cfgs_pkg.sv
// Shared types and helpers for the serial configuration slave.
package cfgs_pkg;

    // Protocol sequencer states.
    typedef enum logic [2:0] {
        ST_IDLE,    // waiting for a start condition
        ST_RX,      // shifting in an address or write byte
        ST_ACK,     // slave acknowledge slot
        ST_TX,      // shifting out a read byte
        ST_MACK,    // waiting for the master's acknowledge bit
        ST_TXWAIT   // master acknowledged, waiting for SCL low to load next byte
    } cfgs_state_e;

    // Two-digit binary-coded decimal of a small count (0..99).
    function automatic logic [7:0] to_bcd(input int unsigned n);
        logic [3:0] tens;
        logic [3:0] ones;
        tens = 4'((n / 10) % 10);
        ones = 4'(n % 10);
        return {tens, ones};
    endfunction

endpackage

// File: rtl/cfgs_line_sync.sv
// Two-wire line conditioner.
// Brings SCL and SDA into the system clock domain through a flop chain,
// then flags SCL edges and the start/stop conditions.
// Assumes every SCL phase lasts several system clocks, so one registered
// copy of each line is enough for edge detection.
module cfgs_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int LINES = 2;   // index 0 = SCL, index 1 = SDA

    logic [LINES-1:0]             raw;
    logic [LINES-1:0][STAGES-1:0] pipe_q;
    logic [LINES-1:0]             last_q;

    assign raw = {sda_i, scl_i};

    for (genvar l = 0; l < LINES; l++) begin : g_line
        // Synchronizer chain plus one delayed copy; lines idle high.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pipe_q[l] <= '1;
                last_q[l] <= 1'b1;
            end else begin
                pipe_q[l] <= {pipe_q[l][STAGES-2:0], raw[l]};
                last_q[l] <= pipe_q[l][STAGES-1];
            end
        end
    end

    assign scl_s     = pipe_q[0][STAGES-1];
    assign sda_s     = pipe_q[1][STAGES-1];
    assign scl_rise  =  scl_s & ~last_q[0];
    assign scl_fall  = ~scl_s &  last_q[0];
    assign start_det =  scl_s & last_q[0] &  last_q[1] & ~sda_s;
    assign stop_det  =  scl_s & last_q[0] & ~last_q[1] &  sda_s;

endmodule

// File: rtl/cfgs_reg_bank.sv
// Configuration register bank.
// One write port fed by the protocol sequencer and one read port with a
// zero result outside the implemented range. The bank is also flattened
// onto a parallel bus.
// Assumes at most one write per clock.
module cfgs_reg_bank #(
    parameter int         NUM_REGS = 12,
    parameter int         IDX_W    = 5,
    parameter logic [7:0] RST_VAL  = 8'hFF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [7:0]            wr_data,
    input  logic [IDX_W-1:0]      rd_idx,
    output logic [7:0]            rd_data,
    output logic [NUM_REGS*8-1:0] bank_o
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic [7:0] val_q;
        // One register: reset to default, load on an addressed write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                val_q <= RST_VAL;
            else if (wr_en && (wr_idx == IDX_W'(g)))
                val_q <= wr_data;
        end
        assign bank_o[g*8 +: 8] = val_q;
    end

    // Read mux, zero when the index is past the last register.
    always_comb begin
        rd_data = 8'h00;
        for (int i = 0; i < NUM_REGS; i++)
            if (rd_idx == IDX_W'(i))
                rd_data = bank_o[i*8 +: 8];
    end

    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(bank_o)); // R4

endmodule

// File: rtl/cfgs_byte_engine.sv
// Protocol sequencer for the serial configuration slave.
// Frames bytes on the conditioned SCL edges, matches the address and
// acknowledges. In a write it skips two header bytes and then issues
// register stores. In a read it returns a BCD register count followed by
// the register contents.
// Assumes conditioned lines from cfgs_line_sync: SDA is sampled on SCL
// rise and the drive changes only after an SCL fall.
module cfgs_byte_engine
    import cfgs_pkg::*;
#(
    parameter int         NUM_REGS = 12,
    parameter int         IDX_W    = 5,
    parameter logic [7:0] WR_ADDR  = 8'hD2,
    parameter logic [7:0] RD_ADDR  = 8'hD3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_s,
    input  logic             sda_s,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic [7:0]       rd_data,
    output logic [IDX_W-1:0] rd_idx,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [7:0]       wr_data,
    output logic             sda_oe
);
    localparam logic [7:0]       COUNT_BCD  = to_bcd(NUM_REGS);
    localparam logic [IDX_W-1:0] IDX_MAX    = '1;
    localparam logic [IDX_W-1:0] FIRST_DATA = IDX_W'(3);   // addr + 2 header bytes
    localparam logic [IDX_W-1:0] FIRST_RD   = IDX_W'(2);   // addr + count byte

    cfgs_state_e      state_q;
    logic             is_read_q;
    logic [2:0]       bit_q;
    logic [7:0]       sh_q;
    logic [IDX_W-1:0] idx_q;     // completed bytes since start, saturating
    logic             oe_q;
    logic             wr_en_q;
    logic [IDX_W-1:0] wr_idx_q;
    logic [7:0]       wr_data_q;

    logic [7:0]       rx_byte;
    logic [IDX_W-1:0] idx_next;
    logic [IDX_W-1:0] data_slot;
    logic             slot_ok;
    logic [7:0]       tx_byte;

    // Byte assembly, index bookkeeping and the next byte to send.
    assign rx_byte   = {sh_q[6:0], sda_s};
    assign idx_next  = (idx_q == IDX_MAX) ? idx_q : idx_q + IDX_W'(1);
    assign data_slot = idx_q - FIRST_DATA;
    assign slot_ok   = (idx_q >= FIRST_DATA) && (data_slot < IDX_W'(NUM_REGS));
    assign rd_idx    = idx_q - FIRST_RD;
    assign tx_byte   = (idx_q == IDX_W'(1)) ? COUNT_BCD : rd_data;

    // Main sequencer: start and stop override every state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            is_read_q <= 1'b0;
            bit_q     <= '0;
            sh_q      <= '0;
            idx_q     <= '0;
            oe_q      <= 1'b0;
            wr_en_q   <= 1'b0;
            wr_idx_q  <= '0;
            wr_data_q <= '0;
        end else begin
            wr_en_q <= 1'b0;
            if (start_det) begin
                state_q   <= ST_RX;
                is_read_q <= 1'b0;
                bit_q     <= '0;
                idx_q     <= '0;
                oe_q      <= 1'b0;
            end else if (stop_det) begin
                state_q <= ST_IDLE;
                oe_q    <= 1'b0;
            end else begin
                case (state_q)
                    ST_IDLE: ;
                    ST_RX: if (scl_rise) begin
                        sh_q <= rx_byte;
                        if (bit_q == 3'd7) begin
                            bit_q <= '0;
                            idx_q <= idx_next;
                            if (idx_q == '0) begin
                                if (rx_byte == WR_ADDR) begin
                                    is_read_q <= 1'b0;
                                    state_q   <= ST_ACK;
                                end else if (rx_byte == RD_ADDR) begin
                                    is_read_q <= 1'b1;
                                    state_q   <= ST_ACK;
                                end else begin
                                    state_q   <= ST_IDLE;
                                end
                            end else begin
                                state_q <= ST_ACK;
                                if (slot_ok) begin
                                    wr_en_q   <= 1'b1;
                                    wr_idx_q  <= data_slot;
                                    wr_data_q <= rx_byte;
                                end
                            end
                        end else begin
                            bit_q <= bit_q + 3'd1;
                        end
                    end
                    ST_ACK: if (scl_fall) begin
                        if (!oe_q) begin
                            oe_q <= 1'b1;
                        end else if (is_read_q) begin
                            sh_q    <= tx_byte;
                            oe_q    <= ~tx_byte[7];
                            bit_q   <= '0;
                            state_q <= ST_TX;
                        end else begin
                            oe_q    <= 1'b0;
                            state_q <= ST_RX;
                        end
                    end
                    ST_TX: if (scl_fall) begin
                        if (bit_q == 3'd7) begin
                            oe_q    <= 1'b0;
                            bit_q   <= '0;
                            idx_q   <= idx_next;
                            state_q <= ST_MACK;
                        end else begin
                            sh_q  <= {sh_q[6:0], 1'b0};
                            oe_q  <= ~sh_q[6];
                            bit_q <= bit_q + 3'd1;
                        end
                    end
                    ST_MACK: if (scl_rise) begin
                        state_q <= sda_s ? ST_IDLE : ST_TXWAIT;
                    end
                    ST_TXWAIT: if (scl_fall) begin
                        sh_q    <= tx_byte;
                        oe_q    <= ~tx_byte[7];
                        bit_q   <= '0;
                        state_q <= ST_TX;
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    assign sda_oe  = oe_q;
    assign wr_en   = wr_en_q;
    assign wr_idx  = wr_idx_q;
    assign wr_data = wr_data_q;

    AST_BAD_ADDR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RX && idx_q == '0 && bit_q == 3'd7 && scl_rise && !start_det && !stop_det
         && rx_byte != WR_ADDR && rx_byte != RD_ADDR) |=> (state_q == ST_IDLE && !sda_oe)); // R2
    AST_HDR_NOT_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (!is_read_q && idx_q > FIRST_DATA)); // R3
    AST_STORE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_idx < IDX_W'(NUM_REGS))); // R5
    AST_TX_BIT_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TX) |-> (sda_oe == !sh_q[7])); // R6
    AST_NACK_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MACK && scl_rise && sda_s && !start_det && !stop_det)
        |=> (state_q == ST_IDLE && !sda_oe)); // R7
    AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_oe) && !$past(start_det) && !$past(stop_det)) |-> !scl_s); // R10

endmodule

// File: rtl/cfg_serial_slave.sv
// Serial configuration slave, top level.
// Chains the line conditioner, the protocol sequencer and the register
// bank. SDA leaves the block as an open-drain enable (1 = pull low).
// Assumes SCL phases of at least 8 system clocks and no clock stretching.
module cfg_serial_slave #(
    parameter int         NUM_REGS    = 12,
    parameter logic [7:0] RST_VAL     = 8'hFF,
    parameter logic [7:0] WR_ADDR     = 8'hD2,
    parameter logic [7:0] RD_ADDR     = 8'hD3,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe_o,
    output logic [NUM_REGS*8-1:0] cfg_o
);
    localparam int IDX_W = $clog2(NUM_REGS + 3) + 1;

    logic             scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx, rd_idx;
    logic [7:0]       wr_data, rd_data;

    cfgs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    cfgs_byte_engine #(
        .NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .WR_ADDR(WR_ADDR), .RD_ADDR(RD_ADDR)
    ) u_engine (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det),
        .rd_data(rd_data), .rd_idx(rd_idx),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .sda_oe(sda_oe_o)
    );

    cfgs_reg_bank #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .RST_VAL(RST_VAL)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_idx(rd_idx), .rd_data(rd_data), .bank_o(cfg_o)
    );

endmodule

// File: tb/sim_cfg_serial_slave.sv
// Scoreboard bench: bus driver tasks queue expected values, a monitor
// process pairs them with what the bus actually showed.
module sim_cfg_serial_slave;
    localparam int CLK_PERIOD = 10;
    localparam int PH         = 10;   // system clocks per SCL phase
    localparam int NREG       = 12;

    typedef struct { string tag; int val; } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_bus;
    logic sda_oe_o;
    logic [NREG*8-1:0] cfg_o;

    int n_checks = 0;
    int n_err = 0;
    bit done = 1'b0;
    item_t exp_q[$];
    int    obs_q[$];
    item_t e_it;
    int    o_v;
    logic [7:0] exp_cfg [NREG];
    int  hi_cnt = 0;
    int  r10_viol = 0;
    logic prev_oe = 1'b0;

    assign sda_bus = m_sda & ~sda_oe_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_serial_slave #(.NUM_REGS(NREG)) u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
        .sda_oe_o(sda_oe_o), .cfg_o(cfg_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Monitor: compare observations against queued expectations.
    initial forever begin
        @(negedge clk);
        while (obs_q.size() > 0 && exp_q.size() > 0) begin
            e_it = exp_q.pop_front();
            o_v  = obs_q.pop_front();
            chk(e_it.tag, o_v, e_it.val);
        end
    end

    // R10 watch: drive must not move during a settled SCL high phase.
    always @(negedge clk) begin
        if (m_scl) hi_cnt = hi_cnt + 1; else hi_cnt = 0;
        if (rst_n && m_scl && hi_cnt >= 4 && sda_oe_o !== prev_oe) r10_viol++;
        prev_oe = sda_oe_o;
    end

    task automatic wait_c(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wait_c(2);
        m_scl = 1'b1; wait_c(PH);
        m_sda = 1'b0; wait_c(PH);
        m_scl = 1'b0; wait_c(2);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wait_c(PH);
        m_scl = 1'b1; wait_c(PH);
        m_sda = 1'b1; wait_c(PH);
    endtask

    task automatic clock_bit(input logic b, output logic s);
        m_sda = b; wait_c(PH);
        m_scl = 1'b1; wait_c(PH/2);
        s = sda_bus; wait_c(PH/2);
        m_scl = 1'b0; wait_c(2);
    endtask

    // Send a byte, queue the expected acknowledge level (0 = acked).
    task automatic put_byte(input logic [7:0] b, input string tag, input int exp_ack);
        logic s;
        for (int i = 7; i >= 0; i--) clock_bit(b[i], s);
        exp_q.push_back('{tag, exp_ack});
        clock_bit(1'b1, s);
        obs_q.push_back(int'(s));
    endtask

    // Receive a byte, answer with mack (0 = ack, 1 = nack).
    task automatic get_byte(input logic mack, input string tag, input int exp_val);
        logic s;
        logic [7:0] v = '0;
        for (int i = 0; i < 8; i++) begin
            clock_bit(1'b1, s);
            v = {v[6:0], s};
        end
        exp_q.push_back('{tag, exp_val});
        clock_bit(mack, s);
        obs_q.push_back(int'(v));
    endtask

    task automatic check_bank(input string tag);
        for (int i = 0; i < NREG; i++)
            chk(tag, int'(cfg_o[i*8 +: 8]), int'(exp_cfg[i]));
    endtask

    initial begin
        for (int i = 0; i < NREG; i++) exp_cfg[i] = 8'hFF;
        wait_c(6);
        rst_n = 1'b1;
        wait_c(4);
        check_bank("R9 reset value");
        chk("R9 SDA released after reset", int'(sda_oe_o), 0);

        // Write three data bytes after the two ignored header bytes.
        bus_start();
        put_byte(8'hD2, "R1 write address ack", 0);
        put_byte(8'hAA, "R3 header byte 1 ack", 0);
        put_byte(8'h55, "R3 header byte 2 ack", 0);
        put_byte(8'h11, "R4 data 0 ack", 0);
        put_byte(8'h22, "R4 data 1 ack", 0);
        put_byte(8'h33, "R4 data 2 ack", 0);
        bus_stop();
        exp_cfg[0] = 8'h11; exp_cfg[1] = 8'h22; exp_cfg[2] = 8'h33;
        check_bank("R3 R4 bank after short write");

        // Read back: count first, then registers; NACK ends the transfer.
        bus_start();
        put_byte(8'hD3, "R2 read address ack", 0);
        get_byte(1'b0, "R6 BCD count", 8'h12);
        get_byte(1'b0, "R6 reg0", 8'h11);
        get_byte(1'b0, "R6 reg1", 8'h22);
        get_byte(1'b1, "R6 reg2 then NACK", 8'h33);
        get_byte(1'b1, "R7 line released after NACK", 8'hFF);
        bus_stop();

        // Wrong address: no ack, slave stays silent afterwards.
        bus_start();
        put_byte(8'hA0, "R2 foreign address not acked", 1);
        put_byte(8'h00, "R2 silent until next start", 1);
        bus_stop();
        check_bank("R2 bank untouched by foreign address");

        // Fill every register plus two extra bytes that must be dropped.
        bus_start();
        put_byte(8'hD2, "R1 write address ack", 0);
        put_byte(8'h01, "R3 header byte 1 ack", 0);
        put_byte(8'h02, "R3 header byte 2 ack", 0);
        for (int i = 0; i < NREG + 2; i++)
            put_byte(8'(8'h40 + i), (i < NREG) ? "R4 data ack" : "R5 overflow byte ack", 0);
        bus_stop();
        for (int i = 0; i < NREG; i++) exp_cfg[i] = 8'(8'h40 + i);
        check_bank("R4 R5 bank after full write");

        // Read past the end: trailing indices return zero.
        bus_start();
        put_byte(8'hD3, "R2 read address ack", 0);
        get_byte(1'b0, "R6 BCD count", 8'h12);
        for (int i = 0; i < NREG; i++)
            get_byte(1'b0, "R6 reg sequence", 8'h40 + i);
        get_byte(1'b0, "R6 past end zero", 8'h00);
        get_byte(1'b1, "R6 past end zero", 8'h00);
        bus_stop();

        // Repeated start in the middle of a data byte, then read.
        bus_start();
        put_byte(8'hD2, "R1 write address ack", 0);
        put_byte(8'h03, "R3 header byte 1 ack", 0);
        put_byte(8'h04, "R3 header byte 2 ack", 0);
        put_byte(8'h77, "R4 data 0 ack", 0);
        begin
            logic s;
            clock_bit(1'b1, s); clock_bit(1'b0, s);
            clock_bit(1'b1, s); clock_bit(1'b0, s);
        end
        bus_start();
        put_byte(8'hD3, "R8 address matched after restart", 0);
        get_byte(1'b0, "R8 BCD count", 8'h12);
        get_byte(1'b0, "R8 reg0 written", 8'h77);
        get_byte(1'b1, "R8 partial byte not stored", 8'h41);
        bus_stop();
        exp_cfg[0] = 8'h77;
        check_bank("R8 bank after aborted byte");

        // Header only, no data: nothing changes.
        bus_start();
        put_byte(8'hD2, "R1 write address ack", 0);
        put_byte(8'hC3, "R3 header byte 1 ack", 0);
        put_byte(8'h3C, "R3 header byte 2 ack", 0);
        bus_stop();
        check_bank("R4 stop after header keeps bank");

        wait_c(4);
        chk("R10 drive changes only while SCL low", r10_viol, 0);
        chk("scoreboard drained", exp_q.size() + obs_q.size(), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

endmodule